// File: doc/BRIEF.md
# Timed Four-Note Tune Sequencer

This block plays a fixed four-note tune by stepping a state machine through a pitch table. A free-running divider on the 12.288 MHz clock produces a single-cycle tick once per second. The machine waits silently until `start` is high at a tick. It then passes through four note states, one per tick, and returns to idle. In each note state it drives a 7-bit terminal count, which a downstream square-wave tone generator uses as its period in 48 kHz samples. In idle the count is zero, which that generator treats as silence.

The start request is checked only at ticks. A press that begins and ends between two ticks therefore has no effect. The tick period and the four pitch counts are parameters, so a small build can walk through every phase of the divider in a short run.

Top module: `tune_seq`

## Requirements
- R1: The divider asserts its internal tick for one cycle on every TICK_CYCLES-th rising edge after reset is released. The first tick falls on edge number TICK_CYCLES. The default of 12,288,000 gives one tick per second at 12.288 MHz.
- R2: While `rst` (synchronous, active high) is sampled high, the machine returns to idle and the divider count clears. After release, `busy` is 0 and `tone_tc` is 0 until a start is accepted.
- R3: Once started, `tone_tc` takes the values 92, 73, 61 and 46 (C5, E5, G5, C6) in that order. Each value is held for exactly TICK_CYCLES cycles, and the machine then returns to idle.
- R4: The machine leaves idle only on a tick edge at which `start` is 1. A start that is high only between ticks leaves the outputs at idle values.
- R5: In idle, `tone_tc` is 0 and `busy` is 0.
- R6: `busy` is 1 in all four note states. A `start` seen while busy neither restarts nor lengthens the tune.
- R7: After the tune returns to idle, a start at a later tick plays it again from the first note. If `start` is held high continuously, consecutive tunes are separated by exactly one tick period of silence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 12.288 MHz clock for the whole block |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Play request, acted on only at a tick |
| busy | output | 1 | High while a note is playing |
| tone_tc | output | TC_W (7) | Terminal count of the current note; 0 means silence |

## Verification
The bench builds the block with TICK_CYCLES = 5 and the default 7-bit count width and pitch values. With this setting a full tune lasts 20 cycles, so the bench can place a one-cycle start pulse at every phase of the divider and check the outputs on every cycle against an arithmetic model of the tick schedule. The short period also makes it practical to run back-to-back replays with `start` held high and to apply a reset at an unaligned phase. After that reset, the first tick has to come exactly five edges after release.

// File: rtl/tune_seq_pkg.sv
package tune_seq_pkg;

   typedef enum logic [2:0] {
      SEQ_IDLE  = 3'd0,
      SEQ_NOTE0 = 3'd1,
      SEQ_NOTE1 = 3'd2,
      SEQ_NOTE2 = 3'd3,
      SEQ_NOTE3 = 3'd4
   } seq_state_e;

   localparam int unsigned NOTE_COUNT      = 4;
   localparam int unsigned DEF_TICK_CYCLES = 12288000;
   localparam int unsigned DEF_TC_W        = 7;

   // Next state taken on a tick edge.
   function automatic seq_state_e seq_advance(input seq_state_e cur, input logic go);
      seq_state_e nxt;
      case (cur)
         SEQ_IDLE:  nxt = go ? SEQ_NOTE0 : SEQ_IDLE;
         SEQ_NOTE0: nxt = SEQ_NOTE1;
         SEQ_NOTE1: nxt = SEQ_NOTE2;
         SEQ_NOTE2: nxt = SEQ_NOTE3;
         default:   nxt = SEQ_IDLE;
      endcase
      return nxt;
   endfunction

endpackage

// File: rtl/tune_tick_div.sv
module tune_tick_div #(
   parameter int unsigned TICK_CYCLES = tune_seq_pkg::DEF_TICK_CYCLES
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);

   if (TICK_CYCLES < 1) begin : g_bad_len
      $error("tune_tick_div: TICK_CYCLES must be at least 1");
   end

   if (TICK_CYCLES == 1) begin : g_every
      // A divide-by-one tick is high on every edge.
      assign tick = 1'b1;
   end else begin : g_count
      localparam int unsigned CNT_W = $clog2(TICK_CYCLES);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

      logic [CNT_W-1:0] cnt;

      always_ff @(posedge clk) begin
         if (rst) begin
            cnt <= '0;
         end else if (cnt == LAST) begin
            cnt <= '0;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end

      assign tick = (cnt == LAST);

      AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
         tick |=> !tick);                                                 // R1
      AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
         cnt <= LAST);                                                    // R1
   end

endmodule

// File: rtl/tune_seq_fsm.sv
module tune_seq_fsm
   import tune_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       tick,
   input  logic       start,
   output seq_state_e state,
   output logic       busy
);

   always_ff @(posedge clk) begin
      if (rst) begin
         state <= SEQ_IDLE;
      end else if (tick) begin
         state <= seq_advance(state, start);
      end
   end

   assign busy = (state != SEQ_IDLE);

   AST_HOLD_OFF_TICK: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(state));                                          // R3
   AST_IDLE_NEEDS_GO: assert property (@(posedge clk) disable iff (rst)
      (state == SEQ_IDLE && !(tick && start)) |=> state == SEQ_IDLE);     // R4
   AST_ORDER_01: assert property (@(posedge clk) disable iff (rst)
      (tick && state == SEQ_NOTE0) |=> state == SEQ_NOTE1);               // R3
   AST_ORDER_12: assert property (@(posedge clk) disable iff (rst)
      (tick && state == SEQ_NOTE1) |=> state == SEQ_NOTE2);               // R3
   AST_ORDER_23: assert property (@(posedge clk) disable iff (rst)
      (tick && state == SEQ_NOTE2) |=> state == SEQ_NOTE3);               // R3
   AST_LAST_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
      (tick && state == SEQ_NOTE3) |=> state == SEQ_IDLE);                // R3
   AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
      (busy && start) |=> state != SEQ_NOTE0 || $past(state) == SEQ_NOTE0); // R6

endmodule

// File: rtl/tune_pitch_map.sv
module tune_pitch_map
   import tune_seq_pkg::*;
#(
   parameter int unsigned TC_W  = DEF_TC_W,
   parameter int unsigned TC_N0 = 92,
   parameter int unsigned TC_N1 = 73,
   parameter int unsigned TC_N2 = 61,
   parameter int unsigned TC_N3 = 46
) (
   input  seq_state_e       state,
   output logic [TC_W-1:0]  tone_tc
);

   localparam int unsigned TC_MAX = (1 << TC_W) - 1;

   if (TC_N0 == 0 || TC_N0 > TC_MAX || TC_N1 == 0 || TC_N1 > TC_MAX ||
       TC_N2 == 0 || TC_N2 > TC_MAX || TC_N3 == 0 || TC_N3 > TC_MAX) begin : g_bad_tc
      $error("tune_pitch_map: each note count must be nonzero and fit in TC_W bits");
   end

   always_comb begin
      case (state)
         SEQ_NOTE0: tone_tc = TC_W'(TC_N0);
         SEQ_NOTE1: tone_tc = TC_W'(TC_N1);
         SEQ_NOTE2: tone_tc = TC_W'(TC_N2);
         SEQ_NOTE3: tone_tc = TC_W'(TC_N3);
         default:   tone_tc = '0;
      endcase
   end

endmodule

// File: rtl/tune_seq.sv
module tune_seq
   import tune_seq_pkg::*;
#(
   parameter int unsigned TICK_CYCLES = DEF_TICK_CYCLES,
   parameter int unsigned TC_W        = DEF_TC_W,
   parameter int unsigned TC_N0       = 92,
   parameter int unsigned TC_N1       = 73,
   parameter int unsigned TC_N2       = 61,
   parameter int unsigned TC_N3       = 46
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            start,
   output logic            busy,
   output logic [TC_W-1:0] tone_tc
);

   if (TC_W < 2 || TC_W > 16) begin : g_bad_width
      $error("tune_seq: TC_W must lie in 2..16");
   end

   logic       tick;
   seq_state_e state;

   tune_tick_div #(
      .TICK_CYCLES (TICK_CYCLES)
   ) u_div (
      .clk  (clk),
      .rst  (rst),
      .tick (tick)
   );

   tune_seq_fsm u_fsm (
      .clk   (clk),
      .rst   (rst),
      .tick  (tick),
      .start (start),
      .state (state),
      .busy  (busy)
   );

   tune_pitch_map #(
      .TC_W  (TC_W),
      .TC_N0 (TC_N0),
      .TC_N1 (TC_N1),
      .TC_N2 (TC_N2),
      .TC_N3 (TC_N3)
   ) u_map (
      .state   (state),
      .tone_tc (tone_tc)
   );

   AST_SILENT_IDLE: assert property (@(posedge clk) disable iff (rst)
      !busy |-> tone_tc == '0);                                           // R5
   AST_AUDIBLE_BUSY: assert property (@(posedge clk) disable iff (rst)
      busy |-> tone_tc != '0);                                            // R6
   AST_RESET_IDLE: assert property (@(posedge clk)
      rst |=> !busy);                                                     // R2

endmodule

// File: tb/tune_seq_tb.sv
`timescale 1ns/1ps
module tune_seq_tb;

   localparam int unsigned TICK = 5;
   localparam int unsigned TC_W = 7;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            start = 1'b0;
   logic            busy;
   logic [TC_W-1:0] tone_tc;

   int checks = 0;
   int errors = 0;
   int n      = 0;   // rising edges since reset release
   int mstate = 0;   // 0 idle, 1..4 notes

   always #2.5 clk = ~clk;

   tune_seq #(.TICK_CYCLES(TICK), .TC_W(TC_W)) u_dut (
      .clk     (clk),
      .rst     (rst),
      .start   (start),
      .busy    (busy),
      .tone_tc (tone_tc)
   );

   function automatic int exp_tc(input int s);
      case (s)
         1: return 92;
         2: return 73;
         3: return 61;
         4: return 46;
         default: return 0;
      endcase
   endfunction

   task automatic chk(input string tag);
      checks++;
      if (busy !== (mstate != 0) || tone_tc !== TC_W'(exp_tc(mstate))) begin
         errors++;
         $display("FAIL %s: edge=%0d actual tone_tc=%0d busy=%0b expected tone_tc=%0d busy=%0b",
                  tag, n, tone_tc, busy, exp_tc(mstate), (mstate != 0));
      end
   endtask

   // Drive start, take one edge, update the model, check after the falling edge.
   task automatic step(input logic s, input string tag);
      start = s;
      @(posedge clk);
      n++;
      if (n % TICK == 0) begin
         case (mstate)
            0: if (s) mstate = 1;
            4: mstate = 0;
            default: mstate = mstate + 1;
         endcase
      end
      @(negedge clk);
      chk(tag);
   endtask

   task automatic do_reset(input logic s_during);
      rst = 1'b1;
      start = s_during;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      mstate = 0;
      n = 0;
      chk("R2");
   endtask

   task automatic align_to_tick;
      while (((n + 1) % TICK) != 0) step(1'b0, "R5");
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      checks++;
      $display("FAIL R1 watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      @(negedge clk);
      do_reset(1'b0);

      // R4: single-cycle start at every non-tick phase is ignored.
      for (int p = 1; p < int'(TICK); p++) begin
         while ((n + 1) % TICK != p) step(1'b0, "R5");
         step(1'b1, "R4");
         repeat (TICK) step(1'b0, "R4");
      end

      // R3 / R1: start pulse aligned with a tick, then the whole tune.
      align_to_tick();
      step(1'b1, "R4");
      repeat (4 * TICK + 3) step(1'b0, "R3");

      // R6 / R7: start held high through two tunes.
      align_to_tick();
      step(1'b1, "R4");
      repeat (4 * TICK) step(1'b1, "R6");
      repeat (6 * TICK) step(1'b1, "R7");
      repeat (5 * TICK) step(1'b0, "R3");

      // R7: a later start after returning to idle replays from the first note.
      align_to_tick();
      step(1'b1, "R7");
      repeat (4 * TICK + 2) step(1'b0, "R7");

      // R2: reset in the middle of a note at an unaligned phase.
      align_to_tick();
      step(1'b1, "R4");
      repeat (TICK + 2) step(1'b0, "R3");
      do_reset(1'b1);
      repeat (2 * TICK) step(1'b1, "R2");
      repeat (5 * TICK) step(1'b0, "R1");

      // R2: reset while idle with start low.
      do_reset(1'b0);
      repeat (2 * TICK) step(1'b0, "R5");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule